// File: doc/BRIEF.md
# VCO Coarse-Band Calibration Controller

This block picks the 7-bit coarse capacitor code of a wide-range oscillator while the phase-locked loop is still held open. For each trial code it waits through a settle interval. It then opens a counting window of a fixed number of reference cycles and counts rising edges of the oscillator output after a fixed power-of-two pre-divider. The count is compared with a target derived from the requested division ratio, and one code bit is resolved per step, most significant bit first. Raising the code adds capacitance and lowers the frequency.

Over a pass the block remembers the trial code whose count came closest to the target, and that code becomes the final band. If even the best trial misses the target by more than a programmable error threshold, the whole pass is run again. A programmable retry limit bounds the number of passes. Once the search ends, the block raises the loop-close indication and presents the chosen code. A failure flag also goes up if the limit ran out.

Top module: `vco_band_cal`

## Requirements
- R1: While reset is applied and after it is released, band_code is 0 and cal_busy, loop_close and cal_fail are all 0.
- R2: A cal_start pulse taken while idle or finished makes cal_busy 1 in the next cycle, drops loop_close and cal_fail, and sets band_code to the first trial 7'h40 (only the top bit set).
- R3: Each step is a settle interval of IDLE_CYC cycles, then a counting window of MEAS_CYC cycles, then a guard of two cycles, after which the count is latched and decided; one step spans IDLE_CYC+MEAS_CYC+4 reference cycles, and a one-pass calibration ends (loop_close seen) 7*(IDLE_CYC+MEAS_CYC+4)+1 sampled cycles after the start.
- R4: The target count is ratio_q*MEAS_CYC/2^PREDIV_LOG2, where ratio_q is the division ratio with 8 fractional bits, and the comparison keeps those 8 fractional bits.
- R5: The trial bit is kept when the count exceeds the target by at least 2 counts and cleared otherwise; the next lower bit is then set for the next trial, so a pass has exactly 7 steps.
- R6: The final code is the trial code with the smallest absolute count error in the pass; on a tie the earlier trial is kept.
- R7: If the smallest error of a pass exceeds err_thresh counts and fewer than max_retry restarts have occurred, a full new pass starts at once, so each restart adds exactly one pass length.
- R8: If the smallest error still exceeds err_thresh after max_retry restarts, the block finishes with cal_fail set to 1 and band_code set to the best code of the last pass.
- R9: loop_close is 1 only once the search has finished, never while cal_busy is 1, and band_code stays constant while loop_close is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cal_start | input | 1 | One-cycle request to start a calibration |
| ratio_q | input | RATIO_W | Requested division ratio, 8 fractional bits |
| err_thresh | input | CNT_W | Largest acceptable best error, in whole counts |
| max_retry | input | RETRY_W | Number of restarts allowed before failing |
| osc_div_in | input | 1 | Pre-divided oscillator output to be counted |
| band_code | output | CODE_W | Coarse code: trial code while searching, chosen code when finished |
| cal_busy | output | 1 | Search in progress |
| loop_close | output | 1 | Search finished; the loop may be closed |
| cal_fail | output | 1 | Search ended with the retry limit exhausted |

## Verification
The bench uses the default build: a 7-bit code, a 16-cycle window, a 4-cycle settle interval and a pre-divide of 4. A behavioural oscillator gives 600-4*code counts per window. With these values every target from band 0 to band 128 can be swept. Each target is set a quarter count below a band, so the ±1 phase uncertainty cannot flip any keep/clear decision or the best-error choice. The bench can then predict the final code exactly. The end targets beyond the code range force failing passes, which bring the restart, retry-limit and exact pass-length behaviour within reach.

// File: rtl/vbc_pkg.sv
`timescale 1ns/1fs
package vbc_pkg;

  typedef enum logic [1:0] {
    CAL_IDLE,
    CAL_STEP,
    CAL_DONE
  } cal_state_t;

  typedef enum logic [1:0] {
    WIN_OFF,
    WIN_SETTLE,
    WIN_MEAS,
    WIN_GUARD
  } win_phase_t;

endpackage

// File: rtl/vbc_window_gen.sv
`timescale 1ns/1fs
module vbc_window_gen
  import vbc_pkg::*;
#(
  parameter int IDLE_CYC  = 4,
  parameter int MEAS_CYC  = 16,
  parameter int GUARD_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  output logic cnt_clr,
  output logic cnt_gate,
  output logic hold_latch,
  output logic meas_ready
);

  localparam int MAXC  = (IDLE_CYC > MEAS_CYC) ? IDLE_CYC : MEAS_CYC;
  localparam int MAXG  = (MAXC > GUARD_CYC) ? MAXC : GUARD_CYC;
  localparam int TMR_W = $clog2(MAXG + 1);

  win_phase_t       phase_q, phase_n;
  logic [TMR_W-1:0] tmr_q, tmr_n;
  logic             ready_q;

  assign cnt_clr    = (phase_q == WIN_SETTLE);
  assign cnt_gate   = (phase_q == WIN_MEAS);
  assign hold_latch = (phase_q == WIN_GUARD) && (tmr_q == '0);
  assign meas_ready = ready_q;

  always_comb begin
    phase_n = phase_q;
    tmr_n   = tmr_q;
    unique case (phase_q)
      WIN_OFF: begin
        if (go) begin
          phase_n = WIN_SETTLE;
          tmr_n   = TMR_W'(IDLE_CYC - 1);
        end
      end
      WIN_SETTLE: begin
        if (tmr_q == '0) begin
          phase_n = WIN_MEAS;
          tmr_n   = TMR_W'(MEAS_CYC - 1);
        end else begin
          tmr_n = tmr_q - 1'b1;
        end
      end
      WIN_MEAS: begin
        if (tmr_q == '0) begin
          phase_n = WIN_GUARD;
          tmr_n   = TMR_W'(GUARD_CYC - 1);
        end else begin
          tmr_n = tmr_q - 1'b1;
        end
      end
      default: begin
        if (tmr_q == '0) begin
          phase_n = WIN_OFF;
        end else begin
          tmr_n = tmr_q - 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= WIN_OFF;
      tmr_q   <= '0;
      ready_q <= 1'b0;
    end else begin
      phase_q <= phase_n;
      tmr_q   <= tmr_n;
      ready_q <= hold_latch;
    end
  end

  AST_SETTLE_BEFORE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cnt_gate) |-> $past(cnt_clr)); // R3

  AST_READY_AFTER_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    meas_ready |-> !cnt_gate && !cnt_clr); // R3

endmodule

// File: rtl/vbc_pulse_counter.sv
`timescale 1ns/1fs
module vbc_pulse_counter #(
  parameter int CNT_W = 12
) (
  input  logic             ref_clk,
  input  logic             osc_clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             gate,
  input  logic             latch,
  output logic [CNT_W-1:0] hold_cnt
);

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [CNT_W-1:0] hold_q;

  assign hold_cnt = hold_q;

  always_comb begin
    cnt_n = cnt_q;
    if (clr) begin
      cnt_n = '0;
    end else if (gate && (cnt_q != '1)) begin
      cnt_n = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge osc_clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else if (latch) begin
      hold_q <= cnt_q;
    end
  end

  AST_LATCH_WINDOW_CLOSED: assert property (@(posedge ref_clk) disable iff (!rst_n)
    latch |-> !gate && !clr); // R3

endmodule

// File: rtl/vbc_sar_core.sv
`timescale 1ns/1fs
module vbc_sar_core
  import vbc_pkg::*;
#(
  parameter int CODE_W  = 7,
  parameter int CNT_W   = 12,
  parameter int FRAC_W  = 8,
  parameter int RETRY_W = 4,
  parameter int Q_W     = 22
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cal_start,
  input  logic [Q_W-1:0]     target_q,
  input  logic [CNT_W-1:0]   err_thresh,
  input  logic [RETRY_W-1:0] max_retry,
  input  logic [CNT_W-1:0]   hold_cnt,
  input  logic               meas_ready,
  output logic               go,
  output logic [CODE_W-1:0]  band_code,
  output logic               cal_busy,
  output logic               loop_close,
  output logic               cal_fail
);

  localparam int BIT_W    = $clog2(CODE_W);
  localparam int MARGIN_I = 2 << FRAC_W;
  localparam logic [CODE_W-1:0] MSB_CODE = {1'b1, {(CODE_W-1){1'b0}}};

  cal_state_t         state_q, state_n;
  logic [CODE_W-1:0]  code_q, code_n;
  logic [BIT_W-1:0]   bit_q, bit_n;
  logic [CODE_W-1:0]  best_code_q, best_code_n;
  logic [Q_W-1:0]     best_err_q, best_err_n;
  logic [RETRY_W-1:0] retry_q, retry_n;
  logic               fail_q, fail_n;
  logic               go_q, go_n;

  logic [Q_W-1:0]     cnt_fx, thresh_fx, abs_err;
  logic signed [Q_W:0] diff;
  logic [CODE_W-1:0]  bit_mask, decided;
  logic               keep, better;

  assign cnt_fx    = Q_W'({hold_cnt, {FRAC_W{1'b0}}});
  assign thresh_fx = Q_W'({err_thresh, {FRAC_W{1'b0}}});
  assign diff      = $signed({1'b0, cnt_fx}) - $signed({1'b0, target_q});
  assign abs_err   = diff[Q_W] ? Q_W'(-diff) : diff[Q_W-1:0];
  assign keep      = (diff >= $signed((Q_W+1)'(MARGIN_I)));
  assign better    = (abs_err < best_err_q);
  assign bit_mask  = CODE_W'(1) << bit_q;
  assign decided   = keep ? code_q : (code_q & ~bit_mask);

  assign go         = go_q;
  assign band_code  = (state_q == CAL_DONE) ? best_code_q : code_q;
  assign cal_busy   = (state_q == CAL_STEP);
  assign loop_close = (state_q == CAL_DONE);
  assign cal_fail   = fail_q;

  always_comb begin
    state_n     = state_q;
    code_n      = code_q;
    bit_n       = bit_q;
    best_code_n = best_code_q;
    best_err_n  = best_err_q;
    retry_n     = retry_q;
    fail_n      = fail_q;
    go_n        = 1'b0;
    if (state_q != CAL_STEP) begin
      if (cal_start) begin
        state_n     = CAL_STEP;
        code_n      = MSB_CODE;
        bit_n       = BIT_W'(CODE_W - 1);
        best_code_n = MSB_CODE;
        best_err_n  = '1;
        retry_n     = '0;
        fail_n      = 1'b0;
        go_n        = 1'b1;
      end
    end else if (meas_ready) begin
      if (better) begin
        best_err_n  = abs_err;
        best_code_n = code_q;
      end
      if (bit_q != '0) begin
        code_n = decided | (bit_mask >> 1);
        bit_n  = bit_q - 1'b1;
        go_n   = 1'b1;
      end else if (best_err_n > thresh_fx) begin
        if (retry_q == max_retry) begin
          state_n = CAL_DONE;
          fail_n  = 1'b1;
        end else begin
          retry_n    = retry_q + 1'b1;
          code_n     = MSB_CODE;
          bit_n      = BIT_W'(CODE_W - 1);
          best_err_n = '1;
          go_n       = 1'b1;
        end
      end else begin
        state_n = CAL_DONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= CAL_IDLE;
      code_q      <= '0;
      bit_q       <= '0;
      best_code_q <= '0;
      best_err_q  <= '1;
      retry_q     <= '0;
      fail_q      <= 1'b0;
      go_q        <= 1'b0;
    end else begin
      state_q     <= state_n;
      code_q      <= code_n;
      bit_q       <= bit_n;
      best_code_q <= best_code_n;
      best_err_q  <= best_err_n;
      retry_q     <= retry_n;
      fail_q      <= fail_n;
      go_q        <= go_n;
    end
  end

  AST_TRIAL_BIT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    cal_busy |-> ((code_q & bit_mask) != '0) && ((code_q & (bit_mask - 1'b1)) == '0)); // R5

  AST_BEST_NONINCREASING: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_busy && $past(cal_busy) && !$past(meas_ready && (bit_q == '0)))
      |-> (best_err_q <= $past(best_err_q))); // R6

  AST_RETRY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cal_busy && $stable(max_retry) |-> (retry_q <= max_retry)); // R7

  AST_FAIL_ONLY_FINISHED: assert property (@(posedge clk) disable iff (!rst_n)
    cal_fail |-> loop_close); // R8

  AST_CODE_STEADY_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_close && $past(loop_close)) |-> $stable(band_code)); // R9

endmodule

// File: rtl/vco_band_cal.sv
`timescale 1ns/1fs
module vco_band_cal #(
  parameter int CODE_W      = 7,
  parameter int CNT_W       = 12,
  parameter int FRAC_W      = 8,
  parameter int RATIO_W     = 16,
  parameter int RETRY_W     = 4,
  parameter int IDLE_CYC    = 4,
  parameter int MEAS_CYC    = 16,
  parameter int PREDIV_LOG2 = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cal_start,
  input  logic [RATIO_W-1:0] ratio_q,
  input  logic [CNT_W-1:0]   err_thresh,
  input  logic [RETRY_W-1:0] max_retry,
  input  logic               osc_div_in,
  output logic [CODE_W-1:0]  band_code,
  output logic               cal_busy,
  output logic               loop_close,
  output logic               cal_fail
);

  localparam int GUARD_CYC = 2;
  localparam int PROD_W    = RATIO_W + $clog2(MEAS_CYC + 1);
  localparam int CQ_W      = CNT_W + FRAC_W;
  localparam int Q_W       = ((PROD_W > CQ_W) ? PROD_W : CQ_W) + 1;

  logic [1:0]        rst_sync_q;
  logic              rst_sync_n;
  logic [PROD_W-1:0] prod;
  logic [Q_W-1:0]    target_q;
  logic              go, cnt_clr, cnt_gate, hold_latch, meas_ready;
  logic [CNT_W-1:0]  hold_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_sync_q[1];

  assign prod     = PROD_W'(ratio_q) * PROD_W'(MEAS_CYC);
  assign target_q = Q_W'(prod >> PREDIV_LOG2);

  vbc_window_gen #(
    .IDLE_CYC  (IDLE_CYC),
    .MEAS_CYC  (MEAS_CYC),
    .GUARD_CYC (GUARD_CYC)
  ) u_win (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .go         (go),
    .cnt_clr    (cnt_clr),
    .cnt_gate   (cnt_gate),
    .hold_latch (hold_latch),
    .meas_ready (meas_ready)
  );

  vbc_pulse_counter #(
    .CNT_W (CNT_W)
  ) u_cnt (
    .ref_clk  (clk),
    .osc_clk  (osc_div_in),
    .rst_n    (rst_sync_n),
    .clr      (cnt_clr),
    .gate     (cnt_gate),
    .latch    (hold_latch),
    .hold_cnt (hold_cnt)
  );

  vbc_sar_core #(
    .CODE_W  (CODE_W),
    .CNT_W   (CNT_W),
    .FRAC_W  (FRAC_W),
    .RETRY_W (RETRY_W),
    .Q_W     (Q_W)
  ) u_core (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .cal_start  (cal_start),
    .target_q   (target_q),
    .err_thresh (err_thresh),
    .max_retry  (max_retry),
    .hold_cnt   (hold_cnt),
    .meas_ready (meas_ready),
    .go         (go),
    .band_code  (band_code),
    .cal_busy   (cal_busy),
    .loop_close (loop_close),
    .cal_fail   (cal_fail)
  );

  AST_BUSY_EXCLUDES_CLOSE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(cal_busy && loop_close)); // R9

endmodule

// File: tb/vco_band_cal_tb_top.sv
`timescale 1ns/1fs
module vco_band_cal_tb_top;

  localparam int    STEP_CYC = 4 + 16 + 4;
  localparam int    PASS_CYC = 7 * STEP_CYC;
  localparam int    K0       = 600;
  localparam real   WIN_NS   = 320.0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cal_start = 1'b0;
  logic [15:0] ratio_q = '0;
  logic [11:0] err_thresh = '0;
  logic [3:0]  max_retry = '0;
  logic        osc = 1'b0;
  logic [6:0]  band_code;
  logic        cal_busy, loop_close, cal_fail;

  int n_total = 0;
  int n_fail  = 0;

  vco_band_cal #(
    .CODE_W(7), .CNT_W(12), .FRAC_W(8), .RATIO_W(16), .RETRY_W(4),
    .IDLE_CYC(4), .MEAS_CYC(16), .PREDIV_LOG2(2)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .cal_start(cal_start), .ratio_q(ratio_q),
    .err_thresh(err_thresh), .max_retry(max_retry), .osc_div_in(osc),
    .band_code(band_code), .cal_busy(cal_busy), .loop_close(loop_close),
    .cal_fail(cal_fail)
  );

  always #10 clk = ~clk;

  // behavioural oscillator: 600 - 4*code rising edges per 320 ns window
  initial begin
    forever begin
      #(WIN_NS / (2.0 * real'(K0 - 4 * int'(band_code))));
      osc = ~osc;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_total++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // ratio giving a target a quarter count below band j
  function automatic logic [15:0] ratio_for(input int j);
    return 16'((K0 - 4 * j) * 64 - 16);
  endfunction

  task automatic run_cal(input logic [15:0] r, input logic [11:0] th, input logic [3:0] mr,
                         output int dur, output int code, output int fl);
    @(negedge clk);
    ratio_q = r; err_thresh = th; max_retry = mr; cal_start = 1'b1;
    @(negedge clk);
    cal_start = 1'b0;
    chk(cal_busy === 1'b1 && band_code === 7'h40 && loop_close === 1'b0 && cal_fail === 1'b0,
        "R2 start trial", int'(band_code), 64);
    dur = 1;
    while (loop_close !== 1'b1 && dur < 4000) begin
      @(negedge clk);
      dur++;
    end
    code = int'(band_code);
    fl   = int'(cal_fail);
    chk(cal_busy === 1'b0, "R9 close only after finish", int'(cal_busy), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_total++;
    n_fail++;
    $display("FAIL R9 watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    int dur, code, fl, d1, d2, d3;
    repeat (3) @(negedge clk);
    chk(band_code === 7'd0 && cal_busy === 1'b0 && loop_close === 1'b0 && cal_fail === 1'b0,
        "R1 in reset", int'(band_code), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(band_code === 7'd0 && cal_busy === 1'b0 && loop_close === 1'b0 && cal_fail === 1'b0,
        "R1 after reset", int'(loop_close), 0);

    // R4 R5 R6: every band as target, decisions and best-error choice
    for (int j = 1; j <= 127; j++) begin
      run_cal(ratio_for(j), 12'd2, 4'd2, dur, code, fl);
      chk(code == j, "R5 R6 final band", code, j);
      chk(fl == 0, "R8 no fail in range", fl, 0);
      if (j == 1 || j == 64 || j == 127)
        chk(dur == PASS_CYC + 1, "R3 one-pass duration", dur, PASS_CYC + 1);
    end

    // R9: code steady while closed
    repeat (20) @(negedge clk);
    chk(loop_close === 1'b1 && band_code === 7'd127, "R9 steady after close", int'(band_code), 127);

    // R8: target above all bands, retry limit 0/1/2
    run_cal(ratio_for(128), 12'd2, 4'd0, d1, code, fl);
    chk(code == 127, "R8 best code on fail", code, 127);
    chk(fl == 1, "R8 fail flag", fl, 1);
    chk(d1 == PASS_CYC + 1, "R7 no restart length", d1, PASS_CYC + 1);
    run_cal(ratio_for(128), 12'd2, 4'd1, d2, code, fl);
    chk(d2 == 2 * PASS_CYC + 1, "R7 one restart length", d2, 2 * PASS_CYC + 1);
    chk(fl == 1, "R8 fail flag after retry", fl, 1);
    run_cal(ratio_for(128), 12'd2, 4'd2, d3, code, fl);
    chk(d3 == 3 * PASS_CYC + 1, "R7 two restart length", d3, 3 * PASS_CYC + 1);
    chk(code == 127 && fl == 1, "R8 code after retries", code, 127);

    // R7: relaxed threshold accepts the same miss in one pass
    run_cal(ratio_for(128), 12'd6, 4'd2, dur, code, fl);
    chk(fl == 0 && dur == PASS_CYC + 1, "R7 threshold accepts", dur, PASS_CYC + 1);
    chk(code == 127, "R6 best when accepted", code, 127);

    // R8: target below all bands, nearest tried code is 1
    run_cal(ratio_for(0), 12'd2, 4'd1, dur, code, fl);
    chk(code == 1 && fl == 1, "R8 low-side fail code", code, 1);

    // R2: restart after a failure clears the flag
    run_cal(ratio_for(40), 12'd2, 4'd2, dur, code, fl);
    chk(code == 40 && fl == 0, "R2 fresh run after fail", code, 40);

    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

endmodule